// File: doc/BRIEF.md
# Two-Thread Transactional Byte Store

This block is a small shared byte array that two requesting threads use through transactions. Each thread has its own command port. A thread opens a transaction, stores bytes into a private speculative copy, and reads bytes back. It then either publishes all of its stored bytes in a single cycle or throws them away. Until a transaction publishes, its stores cannot be seen by the other thread or by any read of the shared array.

The block tracks, for each thread, one bit per byte for the bytes it has read and one bit per byte for the bytes it has stored during the open transaction. When a thread publishes, any open transaction on the other thread that read or stored one of the published bytes is forced to fail. Transactions that touch separate bytes run side by side and can both publish, even in the same cycle. When both threads publish in the same cycle and their sets clash, thread 0 wins. Each port reports success or failure one cycle after a publish or discard request.

Top module: `tsm_buffer`

## Requirements
- R1: After reset every byte of the shared array reads as zero, no transaction is open (`t_busy` low), and `t_done`, `t_fail` and `t_rvalid` are low.
- R2: A store command (op 2) from a thread with no open transaction is ignored, and the shared array keeps its value.
- R3: Bytes stored inside an open transaction are not returned to the other thread, nor to reads of the shared array, until that transaction publishes.
- R4: A read (op 3) inside an open transaction returns the thread's own stored value for a byte it has stored, and the shared value for any other byte.
- R5: A publish (op 4) of an open transaction that has not been forced to fail writes every stored byte to the shared array in the same clock edge. It pulses `t_done` for one cycle in the next cycle and closes the transaction.
- R6: A discard (op 5) closes the transaction, leaves the shared array unchanged and pulses `t_fail` in the next cycle.
- R7: Two open transactions whose read and store sets share no byte can both publish, including in the same cycle, and both sets of stores land.
- R8: When one thread publishes a store set that shares a byte with the other thread's open read set, store set or same-cycle access, the other thread's transaction closes. Its stores are discarded and it pulses `t_fail` in the next cycle.
- R9: When both threads publish in the same cycle and either store set shares a byte with the other thread's read or store set, thread 0 publishes and thread 1 fails.
- R10: A publish with no open transaction pulses `t_fail`, never `t_done`, and changes nothing.
- R11: Read data and `t_rvalid` appear one cycle after the read command. A read in the same cycle as a publish by the other thread returns the value from before that publish.
- R12: A begin (op 1) while a transaction is already open restarts it with empty sets, discarding the earlier stores.
- Command encoding on `t_op`: 0 idle, 1 begin, 2 store, 3 read, 4 publish, 5 discard; 6 and 7 act as idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| t_op | input | NT x 3 | Command per thread |
| t_addr | input | NT x AW | Byte index per thread |
| t_wdata | input | NT x DW | Store data per thread |
| t_rdata | output | NT x DW | Read data, registered |
| t_rvalid | output | NT | Read data valid pulse |
| t_done | output | NT | Publish succeeded pulse |
| t_fail | output | NT | Transaction failed or discarded pulse |
| t_busy | output | NT | Transaction open |

## Verification
The hardest situation to reach is a forced failure that depends on exactly which byte the other thread read or stored before the publish. The failure must be seen while the victim's transaction is still open, and its late publish must then report failure. The bench sweeps every pair of byte indices in both read-victim and store-victim forms. It compares the failure pulse, the busy flag and the resulting array contents against a conflict rule computed from index equality. Same-cycle publishes are driven deliberately, both clashing and disjoint, to reach the tie-break.

// File: rtl/tsm_pkg.sv
package tsm_pkg;
   typedef enum logic [2:0] {
      OP_IDLE   = 3'd0,
      OP_BEGIN  = 3'd1,
      OP_WRITE  = 3'd2,
      OP_READ   = 3'd3,
      OP_COMMIT = 3'd4,
      OP_ABORT  = 3'd5
   } tsm_op_e;
endpackage

// File: rtl/tsm_thread_ctx.sv
module tsm_thread_ctx
   import tsm_pkg::*;
#(
   parameter int NBYTES = 16,
   parameter int DW     = 8,
   localparam int AW    = $clog2(NBYTES)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [2:0]                   op,
   input  logic [AW-1:0]                addr,
   input  logic [DW-1:0]                wdata,
   input  logic                         kill,
   input  logic                         grant,
   input  logic [DW-1:0]                shared_byte,
   output logic                         active,
   output logic                         commit_req,
   output logic [NBYTES-1:0]            wset,
   output logic [NBYTES-1:0]            touch,
   output logic [NBYTES-1:0][DW-1:0]    shadow,
   output logic [DW-1:0]                rdata,
   output logic                         rvalid,
   output logic                         done,
   output logic                         fail
);
   logic              is_begin, is_write, is_read, is_commit, is_abort;
   logic [NBYTES-1:0] rset_q, wset_q, sel;
   logic [DW-1:0]     sh_q [NBYTES];

   assign is_begin  = (op == OP_BEGIN);
   assign is_write  = (op == OP_WRITE);
   assign is_read   = (op == OP_READ);
   assign is_commit = (op == OP_COMMIT);
   assign is_abort  = (op == OP_ABORT);

   assign sel        = NBYTES'(1) << addr;
   assign commit_req = is_commit & active;
   assign wset       = wset_q;
   assign touch      = rset_q | wset_q | ((active & (is_read | is_write)) ? sel : '0);

   for (genvar b = 0; b < NBYTES; b++) begin : g_sh
      assign shadow[b] = sh_q[b];
   end

   always_ff @(posedge clk) begin
      if (active && is_write && !kill) sh_q[addr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         rset_q <= '0;
         wset_q <= '0;
         rdata  <= '0;
         rvalid <= 1'b0;
         done   <= 1'b0;
         fail   <= 1'b0;
      end else begin
         rvalid <= is_read;
         if (is_read) rdata <= (active && wset_q[addr]) ? sh_q[addr] : shared_byte;
         done <= grant;
         fail <= kill | is_abort | (is_commit & ~grant);
         if (is_begin) begin
            active <= 1'b1;
            rset_q <= '0;
            wset_q <= '0;
         end else if (kill || is_abort || is_commit) begin
            active <= 1'b0;
            rset_q <= '0;
            wset_q <= '0;
         end else if (active) begin
            if (is_read)  rset_q <= rset_q | sel;
            if (is_write) wset_q <= wset_q | sel;
         end
      end
   end
endmodule

// File: rtl/tsm_arbiter.sv
module tsm_arbiter #(
   parameter int NBYTES = 16
) (
   input  logic [1:0]              commit_req,
   input  logic [1:0]              active,
   input  logic [1:0][NBYTES-1:0]  wset,
   input  logic [1:0][NBYTES-1:0]  touch,
   output logic [1:0]              kill,
   output logic [1:0]              grant
);
   logic hit01, hit10;

   // hit01: thread 0 stores clash with thread 1 footprint, and the reverse
   assign hit01 = |(wset[0] & touch[1]);
   assign hit10 = |(wset[1] & touch[0]);

   always_comb begin
      kill[1] = commit_req[0] & active[1] & (hit01 | (commit_req[1] & hit10));
      kill[0] = commit_req[1] & ~commit_req[0] & active[0] & hit10;
      grant   = commit_req & ~kill;
   end
endmodule

// File: rtl/tsm_store.sv
module tsm_store #(
   parameter int NT     = 2,
   parameter int NBYTES = 16,
   parameter int DW     = 8,
   localparam int AW    = $clog2(NBYTES)
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic [NT-1:0]                        grant,
   input  logic [NT-1:0][NBYTES-1:0]            wset,
   input  logic [NT-1:0][NBYTES-1:0][DW-1:0]    shadow,
   input  logic [NT-1:0][AW-1:0]                rd_addr,
   output logic [NT-1:0][DW-1:0]                rd_byte
);
   logic [NBYTES-1:0][DW-1:0] cells;

   for (genvar b = 0; b < NBYTES; b++) begin : g_cell
      logic [DW-1:0] cell_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cell_q <= '0;
         end else begin
            // lowest thread index is applied last and so takes priority
            for (int t = NT-1; t >= 0; t--) begin
               if (grant[t] && wset[t][b]) cell_q <= shadow[t][b];
            end
         end
      end
      assign cells[b] = cell_q;
   end

   for (genvar t = 0; t < NT; t++) begin : g_rd
      assign rd_byte[t] = cells[rd_addr[t]];
   end
endmodule

// File: rtl/tsm_buffer.sv
module tsm_buffer #(
   parameter int NT     = 2,
   parameter int NBYTES = 16,
   parameter int DW     = 8,
   parameter int AW     = $clog2(NBYTES)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NT-1:0][2:0]     t_op,
   input  logic [NT-1:0][AW-1:0]  t_addr,
   input  logic [NT-1:0][DW-1:0]  t_wdata,
   output logic [NT-1:0][DW-1:0]  t_rdata,
   output logic [NT-1:0]          t_rvalid,
   output logic [NT-1:0]          t_done,
   output logic [NT-1:0]          t_fail,
   output logic [NT-1:0]          t_busy
);
   if (NT != 2) begin : g_bad_nt
      $error("tsm_buffer supports exactly two threads");
   end
   if (NBYTES < 2 || (1 << AW) != NBYTES) begin : g_bad_nb
      $error("NBYTES must be a power of two, at least 2, matching AW");
   end
   if (DW < 1) begin : g_bad_dw
      $error("DW must be positive");
   end

   logic [NT-1:0]                      commit_req, kill, grant;
   logic [NT-1:0][NBYTES-1:0]          wset, touch;
   logic [NT-1:0][NBYTES-1:0][DW-1:0]  shadow;
   logic [NT-1:0][DW-1:0]              shared_byte;

   for (genvar t = 0; t < NT; t++) begin : g_thr
      tsm_thread_ctx #(.NBYTES(NBYTES), .DW(DW)) u_ctx (
         .clk         (clk),
         .rst_n       (rst_n),
         .op          (t_op[t]),
         .addr        (t_addr[t]),
         .wdata       (t_wdata[t]),
         .kill        (kill[t]),
         .grant       (grant[t]),
         .shared_byte (shared_byte[t]),
         .active      (t_busy[t]),
         .commit_req  (commit_req[t]),
         .wset        (wset[t]),
         .touch       (touch[t]),
         .shadow      (shadow[t]),
         .rdata       (t_rdata[t]),
         .rvalid      (t_rvalid[t]),
         .done        (t_done[t]),
         .fail        (t_fail[t])
      );
   end

   tsm_arbiter #(.NBYTES(NBYTES)) u_arb (
      .commit_req (commit_req),
      .active     (t_busy),
      .wset       (wset),
      .touch      (touch),
      .kill       (kill),
      .grant      (grant)
   );

   tsm_store #(.NT(NT), .NBYTES(NBYTES), .DW(DW)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .grant   (grant),
      .wset    (wset),
      .shadow  (shadow),
      .rd_addr (t_addr),
      .rd_byte (shared_byte)
   );
endmodule

// File: rtl/tsm_buffer_chk.sv
module tsm_buffer_chk
   import tsm_pkg::*;
#(
   parameter int NT     = 2,
   parameter int NBYTES = 16,
   parameter int DW     = 8,
   parameter int AW     = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [NT-1:0][2:0]     t_op,
   input logic [NT-1:0][AW-1:0]  t_addr,
   input logic [NT-1:0][DW-1:0]  t_rdata,
   input logic [NT-1:0]          t_rvalid,
   input logic [NT-1:0]          t_done,
   input logic [NT-1:0]          t_fail,
   input logic [NT-1:0]          t_busy
);
   for (genvar i = 0; i < NT; i++) begin : g_p
      // R5
      done_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
         t_done[i] |-> ($past(t_op[i]) == OP_COMMIT));
      // R5
      status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !(t_done[i] && t_fail[i]));
      // R6
      abort_fails_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (t_op[i] == OP_ABORT) |=> (t_fail[i] && !t_busy[i]));
      // R10
      idle_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (t_op[i] == OP_COMMIT && !t_busy[i]) |=> (t_fail[i] && !t_done[i]));
      // R11
      read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (t_op[i] == OP_READ) |=> t_rvalid[i]);
      // R12
      begin_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (t_op[i] == OP_BEGIN) |=> t_busy[i]);
   end
   // R9
   t0_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (t_op[0] == OP_COMMIT && t_busy[0]) |=> t_done[0]);
endmodule

bind tsm_buffer tsm_buffer_chk #(.NT(NT), .NBYTES(NBYTES), .DW(DW), .AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .t_op(t_op), .t_addr(t_addr), .t_rdata(t_rdata),
   .t_rvalid(t_rvalid), .t_done(t_done), .t_fail(t_fail), .t_busy(t_busy)
);

// File: tb/tb_tsm_buffer.sv
module tb_tsm_buffer;
   localparam int NT = 2, NB = 16, DW = 8, AW = 4;
   localparam logic [2:0] IDL = 3'd0, BEG = 3'd1, WR = 3'd2, RD = 3'd3, CM = 3'd4, AB = 3'd5;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [NT-1:0][2:0]    t_op;
   logic [NT-1:0][AW-1:0] t_addr;
   logic [NT-1:0][DW-1:0] t_wdata;
   logic [NT-1:0][DW-1:0] t_rdata;
   logic [NT-1:0]         t_rvalid, t_done, t_fail, t_busy;

   int errors = 0, checks = 0;
   int model [NB];
   bit finished = 0;

   always #5 clk = ~clk;

   tsm_buffer #(.NT(NT), .NBYTES(NB), .DW(DW), .AW(AW)) dut (.*);

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic cyc(input logic [2:0] o0, input int a0, input int d0,
                      input logic [2:0] o1, input int a1, input int d1);
      t_op[0] = o0; t_addr[0] = AW'(a0); t_wdata[0] = DW'(d0);
      t_op[1] = o1; t_addr[1] = AW'(a1); t_wdata[1] = DW'(d1);
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic rd(input int t, input int a, input string tag, input int exp);
      if (t == 0) cyc(RD, a, 0, IDL, 0, 0); else cyc(IDL, 0, 0, RD, a, 0);
      chk(t_rvalid[t] == 1'b1, "R11 rvalid", int'(t_rvalid[t]), 1);
      chk(int'(t_rdata[t]) == exp, tag, int'(t_rdata[t]), exp);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      int v0, v1;
      bit conf;
      t_op = '0; t_addr = '0; t_wdata = '0;
      for (int i = 0; i < NB; i++) model[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk(t_busy == 2'b00, "R1 busy", int'(t_busy), 0);
      chk(t_done == 2'b00 && t_fail == 2'b00, "R1 status", int'({t_done, t_fail}), 0);
      chk(t_rvalid == 2'b00, "R1 rvalid", int'(t_rvalid), 0);
      for (int i = 0; i < NB; i++) rd(i % 2, i, "R1 zero", 0);

      // R2: store without transaction is ignored
      cyc(WR, 3, 8'hAA, WR, 9, 8'h55);
      rd(0, 3, "R2 ignored", 0);
      rd(1, 9, "R2 ignored", 0);

      // R3/R4/R5: full-array transaction on thread 0
      cyc(BEG, 0, 0, IDL, 0, 0);
      for (int i = 0; i < NB; i++) cyc(WR, i, (i*37+5) & 255, IDL, 0, 0);
      for (int i = 0; i < NB; i++) rd(1, i, "R3 hidden", model[i]);
      for (int i = 0; i < NB; i++) rd(0, i, "R4 own", (i*37+5) & 255);
      cyc(CM, 0, 0, IDL, 0, 0);
      chk(t_done[0] == 1'b1 && t_fail[0] == 1'b0, "R5 done", int'(t_done[0]), 1);
      chk(t_busy[0] == 1'b0, "R5 closed", int'(t_busy[0]), 0);
      for (int i = 0; i < NB; i++) model[i] = (i*37+5) & 255;
      for (int i = 0; i < NB; i++) rd(1, i, "R5 published", model[i]);

      // R6: discard on thread 1
      cyc(IDL, 0, 0, BEG, 0, 0);
      for (int i = 0; i < NB; i++) cyc(IDL, 0, 0, WR, i, (~model[i]) & 255);
      cyc(IDL, 0, 0, AB, 0, 0);
      chk(t_fail[1] == 1'b1 && t_done[1] == 1'b0, "R6 fail", int'(t_fail[1]), 1);
      for (int i = 0; i < NB; i++) rd(0, i, "R6 unchanged", model[i]);

      // R4: partial buffer, unstored byte reads shared
      cyc(IDL, 0, 0, BEG, 0, 0);
      cyc(IDL, 0, 0, WR, 2, 8'h3C);
      rd(1, 2, "R4 stored", 8'h3C);
      rd(1, 7, "R4 shared", model[7]);
      cyc(IDL, 0, 0, AB, 0, 0);

      // R7: disjoint ranges, same-cycle publish
      cyc(BEG, 0, 0, BEG, 0, 0);
      for (int i = 0; i < 5; i++) cyc(WR, i, 100 + i, WR, i + 5, 200 + i);
      cyc(RD, 4, 0, RD, 9, 0);
      cyc(CM, 0, 0, CM, 0, 0);
      chk(t_done == 2'b11, "R7 both done", int'(t_done), 3);
      chk(t_fail == 2'b00, "R7 no fail", int'(t_fail), 0);
      for (int i = 0; i < 5; i++) begin model[i] = 100 + i; model[i+5] = 200 + i; end
      for (int i = 0; i < 10; i++) rd(0, i, "R7 landed", model[i]);

      // R8: conflict sweep over every byte pair, read-victim and store-victim
      for (int m = 0; m < 2; m++) begin
         for (int a0 = 0; a0 < NB; a0++) begin
            for (int a1 = 0; a1 < NB; a1++) begin
               v0 = (a0*7 + a1*3 + m + 1) & 255;
               v1 = v0 ^ 8'h5A;
               conf = (a0 == a1);
               cyc(BEG, 0, 0, BEG, 0, 0);
               cyc(WR, a0, v0, (m == 1) ? WR : RD, a1, v1);
               cyc(CM, 0, 0, IDL, 0, 0);
               chk(t_done[0] == 1'b1, "R8 winner done", int'(t_done[0]), 1);
               chk(t_fail[1] == conf, "R8 victim fail", int'(t_fail[1]), int'(conf));
               chk(t_busy[1] == !conf, "R8 victim open", int'(t_busy[1]), int'(!conf));
               cyc(IDL, 0, 0, CM, 0, 0);
               chk(t_done[1] == !conf && t_fail[1] == conf, "R10 late publish",
                   int'(t_done[1]), int'(!conf));
               model[a0] = v0;
               if (m == 1 && !conf) model[a1] = v1;
               rd(0, a0, "R8 byte a0", model[a0]);
               rd(0, a1, "R8 byte a1", model[a1]);
            end
         end
      end

      // R9: same-cycle clash, store/store
      cyc(BEG, 0, 0, BEG, 0, 0);
      cyc(WR, 6, 8'h11, WR, 6, 8'h22);
      cyc(CM, 0, 0, CM, 0, 0);
      chk(t_done[0] == 1'b1 && t_fail[1] == 1'b1, "R9 t0 wins", int'({t_done[0], t_fail[1]}), 3);
      chk(t_done[1] == 1'b0, "R9 t1 no done", int'(t_done[1]), 0);
      model[6] = 8'h11;
      rd(1, 6, "R9 value", model[6]);
      // R9: thread 1 stores what thread 0 read
      cyc(BEG, 0, 0, BEG, 0, 0);
      cyc(RD, 4, 0, WR, 4, 8'h77);
      cyc(CM, 0, 0, CM, 0, 0);
      chk(t_done[0] == 1'b1 && t_fail[1] == 1'b1, "R9 read clash", int'({t_done[0], t_fail[1]}), 3);
      rd(0, 4, "R9 unchanged", model[4]);

      // R10: publish with nothing open
      cyc(CM, 0, 0, IDL, 0, 0);
      chk(t_fail[0] == 1'b1 && t_done[0] == 1'b0, "R10 fail", int'(t_fail[0]), 1);

      // R11: read concurrent with other thread's publish sees old value
      cyc(BEG, 0, 0, IDL, 0, 0);
      cyc(WR, 1, 8'hE1, IDL, 0, 0);
      cyc(CM, 0, 0, RD, 1, 0);
      chk(int'(t_rdata[1]) == model[1], "R11 pre-publish", int'(t_rdata[1]), model[1]);
      model[1] = 8'hE1;
      rd(1, 1, "R11 post-publish", model[1]);

      // R12: restart discards earlier stores
      cyc(IDL, 0, 0, BEG, 0, 0);
      cyc(IDL, 0, 0, WR, 8, 8'h99);
      cyc(IDL, 0, 0, BEG, 0, 0);
      chk(t_busy[1] == 1'b1, "R12 open", int'(t_busy[1]), 1);
      cyc(IDL, 0, 0, CM, 0, 0);
      chk(t_done[1] == 1'b1, "R12 done", int'(t_done[1]), 1);
      rd(0, 8, "R12 dropped", model[8]);

      cyc(IDL, 0, 0, IDL, 0, 0);
      finish_run();
   end
endmodule